// File: doc/BRIEF.md
# Overcurrent Delay and Shutdown Latch

This block watches a stream of 8-bit current samples, each tagged with the channel it belongs to. Each sample is compared with that channel's programmable limit. A sample counts as an excursion only when it is strictly above the limit. An all-ones limit turns the comparison off for that channel.

Every channel keeps two separate counters of consecutive excursions. The status counter raises a sticky per-channel overcurrent flag. A flag that gets set can also raise an interrupt request. The shutdown counter sets a single latch that drives the hardware shutdown output. Each path has its own delay value and its own reset bit. The limits, delays and strobes come from a register interface that lives outside this block. So does the bus-side alert arbitration.

Top module: `oc_shutdown_guard`

## Requirements
- R1: A sample on channel c is an excursion only when `smp_data` is strictly greater than limit c (`thr_flat[8c+7:8c]`). A sample of channel c that is equal to or below the limit resets both of channel c's counters to zero. Samples tagged with other channels leave channel c's counters unchanged.
- R2: With the status delay field `st_dly[6:0]` = N, status bit c (`oc_status[c]`) sets on the clock edge that takes in the (N+1)-th consecutive excursion of channel c. N = 0 sets it on the first excursion.
- R3: A limit of 8'hFF means channel c never records an excursion, whatever its samples are.
- R4: Status bits are sticky. A cycle with `st_wr` high clears every bit c whose `st_wdata[c]` is 0 and leaves the bits written 1 unchanged. A set event in the same cycle as a clear wins. After a clear, a bit sets again only after a fresh run of N+1 excursions, so an excursion run that simply continues does not set it again.
- R5: While `st_dly[7]` is 1, all status counters are held at zero, no status bit can set, and `oc_status` reads 0 after the next edge.
- R6: With the shutdown delay field `sd_dly[6:0]` = M, `shdn` goes high on the edge that takes in the (M+1)-th consecutive excursion of any one channel. It then stays high when the samples fall back below the limit.
- R7: While `sd_dly[7]` is 1, the shutdown counters are held at zero and `shdn` is low after the next edge. After the bit is released, a full new run of M+1 excursions is needed to set `shdn`.
- R8: While `ena` is low, the shutdown latch and counters are cleared and `shdn` is low after the next edge. With `ena` high, the latch works normally.
- R9: `irq` rises on any edge where a status bit is set while `alert_en` is 1. It stays high until a cycle with `st_acc`, `st_wr` or `ara_won`. When `alert_en` is 0, `irq` is low after the next edge.
- R10: The status path and the shutdown path count against their own delays, so one run of excursions can set a status bit and `shdn` on different samples.
- R11: After reset, `oc_status`, `irq` and `shdn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 2 | Channel tag of the sample |
| smp_data | input | 8 | Raw sample value |
| thr_flat | input | 32 | Per-channel limits, channel c in bits 8c+7:8c |
| st_dly | input | 8 | Status delay: bit 7 holds the path in reset, bits 6:0 give N |
| sd_dly | input | 8 | Shutdown delay: bit 7 holds the path in reset, bits 6:0 give M |
| alert_en | input | 1 | Allows the interrupt request |
| ena | input | 1 | Shutdown latch enable, active high |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 4 | Status write data, a 0 clears the matching bit |
| st_acc | input | 1 | Status read strobe, clears `irq` |
| ara_won | input | 1 | Alert arbitration won, clears `irq` |
| oc_status | output | 4 | Sticky per-channel overcurrent flags |
| irq | output | 1 | Interrupt request |
| shdn | output | 1 | Latched shutdown output |

## Verification
The checker checks on every cycle the forcing rules:
- the reset bits and a low `ena` force their outputs low;
- `alert_en` gates `irq`;
- status bits never drop without a write or reset;
- the shutdown latch holds while nothing clears it;
- a clear strobe with no set event drops `irq`.

The exact sample on which a run of excursions fires can only be shown by the bench's scenarios. These cover:
- off-by-one delays;
- the strict-greater comparison at the limit;
- runs interleaved with other channels' samples;
- re-arming after a clear during a continuing run;
- the different timing of the two paths.

// File: rtl/ocd_pkg.sv
`timescale 1ns/1ps
package ocd_pkg;
  localparam int SMP_W = 8;
  localparam int DLY_W = 8;
  localparam logic [SMP_W-1:0] THR_DEFAULT = 8'hD1;
  localparam logic [DLY_W-1:0] ST_DLY_DEFAULT = 8'h04;
  localparam logic [DLY_W-1:0] SD_DLY_DEFAULT = 8'h14;
endpackage

// File: rtl/ocd_run_counter.sv
`timescale 1ns/1ps
// Consecutive-excursion counter; fires once per run when the target is reached
module ocd_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             over,
  input  logic [CNT_W-1:0] target,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;

  function automatic logic f_reaches(logic [CNT_W-1:0] c, logic [CNT_W-1:0] t);
    return (c < t) && ((c + CNT_W'(1)) == t);
  endfunction

  assign fire = !hold && tick && over && f_reaches(cnt, target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold) begin
      cnt <= '0;
    end else if (tick) begin
      if (!over)
        cnt <= '0;
      else if (cnt < target)
        cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ocd_channel.sv
`timescale 1ns/1ps
// One channel: limit comparator plus status and shutdown run counters
module ocd_channel #(
  parameter int SMP_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SMP_W-1:0] sample,
  input  logic [SMP_W-1:0] limit,
  input  logic [CNT_W-1:0] st_target,
  input  logic [CNT_W-1:0] sd_target,
  input  logic             st_hold,
  input  logic             sd_hold,
  output logic             over,
  output logic             st_fire,
  output logic             sd_fire
);
  // all-ones limit disables the comparator
  function automatic logic f_over(logic [SMP_W-1:0] s, logic [SMP_W-1:0] t);
    return (t != {SMP_W{1'b1}}) && (s > t);
  endfunction

  assign over = tick && f_over(sample, limit);

  ocd_run_counter #(.CNT_W(CNT_W)) u_st_cnt (
    .clk(clk), .rst_n(rst_n), .hold(st_hold), .tick(tick), .over(over),
    .target(st_target), .fire(st_fire)
  );

  ocd_run_counter #(.CNT_W(CNT_W)) u_sd_cnt (
    .clk(clk), .rst_n(rst_n), .hold(sd_hold), .tick(tick), .over(over),
    .target(sd_target), .fire(sd_fire)
  );
endmodule

// File: rtl/ocd_flags.sv
`timescale 1ns/1ps
// Sticky status bits, interrupt request and shutdown latch
module ocd_flags #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] st_fire,
  input  logic           sd_fire_any,
  input  logic           st_hold,
  input  logic           sd_hold,
  input  logic           st_wr,
  input  logic [NCH-1:0] st_wdata,
  input  logic           irq_clr,
  input  logic           alert_en,
  output logic [NCH-1:0] status,
  output logic           irq,
  output logic           shdn
);
  logic [NCH-1:0] keep_mask;
  assign keep_mask = st_wr ? st_wdata : {NCH{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
      shdn   <= 1'b0;
    end else begin
      status <= st_hold ? '0 : ((status & keep_mask) | st_fire);
      irq    <= alert_en && ((|st_fire) || (irq && !irq_clr));
      shdn   <= sd_hold ? 1'b0 : (shdn | sd_fire_any);
    end
  end
endmodule

// File: rtl/oc_shutdown_guard.sv
`timescale 1ns/1ps
module oc_shutdown_guard #(
  parameter int NCH   = 4,
  parameter int SMP_W = ocd_pkg::SMP_W,
  parameter int DLY_W = ocd_pkg::DLY_W,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CNT_W = DLY_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [CHW-1:0]       smp_chan,
  input  logic [SMP_W-1:0]     smp_data,
  input  logic [NCH*SMP_W-1:0] thr_flat,
  input  logic [DLY_W-1:0]     st_dly,
  input  logic [DLY_W-1:0]     sd_dly,
  input  logic                 alert_en,
  input  logic                 ena,
  input  logic                 st_wr,
  input  logic [NCH-1:0]       st_wdata,
  input  logic                 st_acc,
  input  logic                 ara_won,
  output logic [NCH-1:0]       oc_status,
  output logic                 irq,
  output logic                 shdn
);
  // delay field N means N+1 consecutive excursions
  function automatic logic [CNT_W-1:0] f_target(logic [DLY_W-2:0] n);
    return CNT_W'(n) + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] st_target, sd_target;
  logic             st_hold, sd_hold;
  logic [NCH-1:0]   over_vec, st_fire_vec, sd_fire_vec, tick_vec;

  assign st_target = f_target(st_dly[DLY_W-2:0]);
  assign sd_target = f_target(sd_dly[DLY_W-2:0]);
  assign st_hold   = st_dly[DLY_W-1];
  assign sd_hold   = sd_dly[DLY_W-1] || !ena;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign tick_vec[c] = smp_valid && (smp_chan == CHW'(c));
    ocd_channel #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick_vec[c]), .sample(smp_data),
      .limit(thr_flat[c*SMP_W +: SMP_W]),
      .st_target(st_target), .sd_target(sd_target),
      .st_hold(st_hold), .sd_hold(sd_hold),
      .over(over_vec[c]), .st_fire(st_fire_vec[c]), .sd_fire(sd_fire_vec[c])
    );
  end

  ocd_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .st_fire(st_fire_vec), .sd_fire_any(|sd_fire_vec),
    .st_hold(st_hold), .sd_hold(sd_hold), .st_wr(st_wr), .st_wdata(st_wdata),
    .irq_clr(st_acc || st_wr || ara_won), .alert_en(alert_en),
    .status(oc_status), .irq(irq), .shdn(shdn)
  );
endmodule

// File: rtl/ocd_guard_chk.sv
`timescale 1ns/1ps
module ocd_guard_chk #(
  parameter int NCH   = 4,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DLY_W-1:0] st_dly,
  input logic [DLY_W-1:0] sd_dly,
  input logic             ena,
  input logic             alert_en,
  input logic             st_wr,
  input logic             st_acc,
  input logic             ara_won,
  input logic [NCH-1:0]   st_fire_vec,
  input logic [NCH-1:0]   oc_status,
  input logic             irq,
  input logic             shdn
);
  a_r5_status_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st_dly[DLY_W-1] |=> (oc_status == '0));

  a_r7_sd_reset_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dly[DLY_W-1] |=> !shdn);

  a_r8_enable_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> !shdn);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_en |=> !irq);

  a_r9_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_fire_vec == '0) && (st_acc || st_wr || ara_won)) |=> !irq);

  a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_wr && !st_dly[DLY_W-1]) |=> (($past(oc_status) & ~oc_status) == '0));

  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn && ena && !sd_dly[DLY_W-1]) |=> shdn);
endmodule

bind oc_shutdown_guard ocd_guard_chk #(.NCH(NCH), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_dly(st_dly), .sd_dly(sd_dly), .ena(ena),
  .alert_en(alert_en), .st_wr(st_wr), .st_acc(st_acc), .ara_won(ara_won),
  .st_fire_vec(st_fire_vec), .oc_status(oc_status), .irq(irq), .shdn(shdn)
);

// File: tb/sim_oc_shutdown_guard.sv
`timescale 1ns/1ps
module sim_oc_shutdown_guard;
  import ocd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [7:0]  smp_data = '0;
  logic [31:0] thr_flat = {4{THR_DEFAULT}};
  logic [7:0]  st_dly = ST_DLY_DEFAULT;
  logic [7:0]  sd_dly = SD_DLY_DEFAULT;
  logic        alert_en = 1'b1;
  logic        ena = 1'b1;
  logic        st_wr = 1'b0;
  logic [3:0]  st_wdata = '0;
  logic        st_acc = 1'b0;
  logic        ara_won = 1'b0;
  logic [3:0]  oc_status;
  logic        irq, shdn;

  always #2 clk = ~clk;

  oc_shutdown_guard u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .thr_flat(thr_flat), .st_dly(st_dly), .sd_dly(sd_dly),
    .alert_en(alert_en), .ena(ena), .st_wr(st_wr), .st_wdata(st_wdata),
    .st_acc(st_acc), .ara_won(ara_won), .oc_status(oc_status), .irq(irq), .shdn(shdn)
  );

  typedef struct {
    logic [3:0] st;
    logic       irq;
    logic       sh;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag = "R11";

  // reference state, built from the requirement text
  int         m_st[4];
  int         m_sd[4];
  logic [3:0] m_stat = '0;
  logic       m_irq = 1'b0;
  logic       m_shdn = 1'b0;

  task automatic check(string tag, logic [3:0] ast, logic ai, logic ash,
                       logic [3:0] est, logic ei, logic esh);
    n_checks++;
    if (ast !== est || ai !== ei || ash !== esh) begin
      n_errors++;
      $display("FAIL %s: status=%b irq=%b shdn=%b, expected status=%b irq=%b shdn=%b",
               tag, ast, ai, ash, est, ei, esh);
    end
  endtask

  task automatic model_tick();
    logic [3:0] stf;
    logic       sdf;
    logic       sd_rst;
    int         ts, td;
    stf = '0;
    sdf = 1'b0;
    sd_rst = sd_dly[7] || !ena;
    ts = int'(st_dly[6:0]) + 1;
    td = int'(sd_dly[6:0]) + 1;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] lim;
      logic       mine, ex;
      lim  = thr_flat[8*i +: 8];
      mine = smp_valid && (int'(smp_chan) == i);
      ex   = mine && (lim != 8'hFF) && (smp_data > lim);
      if (st_dly[7]) m_st[i] = 0;
      else if (mine) begin
        if (ex) begin
          if (m_st[i] + 1 == ts) stf[i] = 1'b1;
          if (m_st[i] < ts) m_st[i]++;
        end else m_st[i] = 0;
      end
      if (sd_rst) m_sd[i] = 0;
      else if (mine) begin
        if (ex) begin
          if (m_sd[i] + 1 == td) sdf = 1'b1;
          if (m_sd[i] < td) m_sd[i]++;
        end else m_sd[i] = 0;
      end
    end
    if (st_dly[7]) m_stat = '0;
    else m_stat = (m_stat & (st_wr ? st_wdata : 4'hF)) | stf;
    m_irq  = alert_en && ((|stf) || (m_irq && !(st_acc || st_wr || ara_won)));
    m_shdn = sd_rst ? 1'b0 : (m_shdn | sdf);
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(bit v, int ch, int d);
    exp_t e;
    @(negedge clk);
    smp_valid = v;
    smp_chan  = ch[1:0];
    smp_data  = d[7:0];
    model_tick();
    @(posedge clk);
    #1;
    e.st = m_stat; e.irq = m_irq; e.sh = m_shdn; e.tag = cur_tag;
    q.push_back(e);
    st_wr = 1'b0; st_acc = 1'b0; ara_won = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic run(int ch, int d, int n);
    for (int k = 0; k < n; k++) step(1'b1, ch, d);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() != 0) begin
      e = q.pop_front();
      check(e.tag, oc_status, irq, shdn, e.st, e.irq, e.sh);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_sd[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", oc_status, irq, shdn, 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;

    cur_tag = "R2";                       // run of 5 on ch0, ch1 sample in between
    run(0, 8'hD2, 4); step(1, 1, 8'h10); step(1, 0, 8'hD2);
    cur_tag = "R9";  st_acc = 1'b1; step(0, 0, 0);
    cur_tag = "R1";                       // sample equal to limit restarts the run
    run(1, 8'hD2, 3); step(1, 1, 8'hD1); run(1, 8'hD2, 5);
    cur_tag = "R9";  ara_won = 1'b1; step(0, 0, 0);
    cur_tag = "R3";  thr_flat[23:16] = 8'hFF; run(2, 8'hFF, 8);
    cur_tag = "R4";                       // clear during a continuing run
    st_wr = 1'b1; st_wdata = 4'b1110; run(0, 8'hD2, 6);
    step(1, 0, 8'h00); run(0, 8'hD2, 5);
    st_wr = 1'b1; st_wdata = 4'b1110; step(1, 0, 8'h00); run(0, 8'hD2, 4);
    st_wr = 1'b1; st_wdata = 4'b1110; step(1, 0, 8'hD2);
    cur_tag = "R9";  alert_en = 1'b0; step(0, 0, 0); run(3, 8'hD2, 5);
    alert_en = 1'b1;
    cur_tag = "R6";  sd_dly = 8'h02; step(1, 3, 8'h05); run(3, 8'hE0, 3); run(3, 8'h01, 2);
    cur_tag = "R8";  ena = 1'b0; step(0, 0, 0); ena = 1'b1; run(0, 8'hD2, 3);
    cur_tag = "R7";  sd_dly = 8'h82; step(0, 0, 0); run(0, 8'hD2, 4);
    sd_dly = 8'h02; run(0, 8'hD2, 3);
    cur_tag = "R5";  st_dly = 8'h84; step(0, 0, 0); run(1, 8'hD2, 6);
    st_dly = 8'h04; run(1, 8'hD2, 5);
    cur_tag = "R10";
    ena = 1'b0; step(0, 0, 0); ena = 1'b1;
    st_wr = 1'b1; st_wdata = 4'b0000; step(0, 0, 0);
    st_dly = 8'h00; sd_dly = 8'h03; thr_flat[23:16] = THR_DEFAULT;
    step(1, 2, 8'h00); run(2, 8'hD2, 4);

    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule